// File: doc/BRIEF.md
# Four-Switch Space-Vector Duty Calculator

This block turns a reference angle and a modulation depth into the dwell times that a pulse generator needs for one half switching period of a three-phase inverter. The inverter has only two switched legs, and the third phase sits on the midpoint of a split DC link. The block still treats the reference plane as a six-sector hexagon. Only two hexagon corners, V1 and V3, exist as physical states. The other four corners are mean vectors of two neighbouring physical states, and the zero vector is the mean of V1 and V3. Each synthesized vector is realised by giving each of its two physical states half of its time. The result is the sector number and the on-time of each of the four physical vectors V1 to V4 for the half period.

A request carries a 16-bit phase-accumulator angle (a full turn is 2^16), a modulation index (4096 stands for 1.0), and the half-period length in clock ticks. Requests use a valid/ready handshake. `in_ready` is high only while the block is idle and has no result waiting. A request is taken on a clock edge where both `in_valid` and `in_ready` are high. The result appears on `out_valid` and is held unchanged until a clock edge where `out_ready` is high. While a result waits, `in_ready` stays low, so a stalled consumer stalls the producer. Sine values come from an internal quarter-wave table of 256 entries.

Top module: `svpwm4_duty`

## Requirements
- R1: With p = angle·6, the sector index is s = p >> 16 (0..5), reported on `out_sector` as s+1 (1..6). The in-sector remainder is r = p mod 2^16.
- R2: Table entry i (0..255) equals floor(4095·sin(i·90°/256)). The first active vector uses the entry at address ((2^16 − r)·171) >> 16. The second active vector uses the entry at address (r·171) >> 16.
- R3: Each active time is floor(H·M·S·7094 / 2^36). H is the half-period in ticks, M is the index input, and S is the table value for that vector.
- R4: When the two active times tx and ty sum to no more than H, they are used unchanged and the zero time is H − tx − ty.
- R5: When tx + ty > H, the first time becomes floor(tx·H/(tx+ty)), the second becomes H minus that value, and the zero time is 0.
- R6: The hexagon corners in angular order 0..5 are V23M, V3, V34M, V41M, V1, V12M. Sector s applies corner s for the first time and corner (s+1) mod 6 for the second.
- R7: A mean vector's time t goes floor(t/2) to its lower-numbered base and the rest to the other base. The zero time goes floor(t0/2) to V1 and the rest to V3.
- R8: The four base-vector times of every result sum exactly to H.
- R9: A result becomes valid on the fourth clock edge after acceptance. It stays valid and unchanged while `out_ready` is low. `in_ready` is low whenever a result is valid.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, and the sector and time outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_angle | input | 16 | Reference angle, full turn = 2^16 |
| in_mod | input | 12 | Modulation index, 4096 = 1.0 |
| in_half | input | 16 | Half-period length in clock ticks |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sector | output | 3 | Sector number 1..6 |
| out_t1 | output | 16 | On-time of V1 |
| out_t2 | output | 16 | On-time of V2 |
| out_t3 | output | 16 | On-time of V3 |
| out_t4 | output | 16 | On-time of V4 |

## Verification
Two events can coincide at the handshake: a new request arriving, and a finished result waiting for a stalled consumer. The bench provokes this by holding `out_ready` low while it offers a second request with different data. During the stall it requires `in_ready` to stay low and the held times to stay equal to the first request's expected values. After `out_ready` rises, it requires the second request to be taken and its own result to appear four edges later. Separately, the sweeps cover linear and overmodulated operating points in every sector, including the exact angles at sector boundaries.

// File: rtl/svpwm4_pkg.sv
package svpwm4_pkg;
  localparam int SECTORS    = 6;
  // sqrt(3) in unsigned fixed point with 12 fraction bits
  localparam int SQRT3_K    = 7094;
  localparam int SQRT3_W    = 13;
  localparam int SQRT3_FRAC = 12;

  typedef enum logic [2:0] {ST_IDLE, ST_LOOK, ST_MUL, ST_FIT, ST_MAP} stage_e;

  // hexagon corners in angular order
  typedef enum logic [2:0] {HV_M23, HV_B3, HV_M34, HV_M41, HV_B1, HV_M12} hexv_e;

  function automatic hexv_e hex_at(logic [2:0] k);
    return (k < 3'(SECTORS)) ? hexv_e'(k) : HV_M23;
  endfunction
endpackage

// File: rtl/svpwm4_sector_split.sv
module svpwm4_sector_split #(
  parameter int ANG_W  = 16,
  parameter int ROM_AW = 8
) (
  input  logic [ANG_W-1:0]  angle,
  output logic [2:0]        sec,
  output logic [ROM_AW-1:0] idx_x,
  output logic [ROM_AW-1:0] idx_y
);
  localparam int DEPTH   = 1 << ROM_AW;
  localparam int IDX_MUL = (2 * DEPTH + 2) / 3;   // table span of 60 degrees
  localparam int MUL_W   = $clog2(IDX_MUL + 1);
  localparam int P6_W    = ANG_W + 3;
  localparam int SC_W    = ANG_W + MUL_W + 1;

  logic [P6_W-1:0]  p6;
  logic [ANG_W-1:0] rem;
  logic [ANG_W:0]   rem_c;
  logic [SC_W-1:0]  scl_x, scl_y;

  always_comb begin
    p6    = P6_W'(angle) * P6_W'(6);
    sec   = p6[P6_W-1:ANG_W];
    rem   = p6[ANG_W-1:0];
    rem_c = {1'b1, {ANG_W{1'b0}}} - {1'b0, rem};
    scl_y = SC_W'(rem)   * SC_W'(IDX_MUL);
    scl_x = SC_W'(rem_c) * SC_W'(IDX_MUL);
    idx_y = ROM_AW'(scl_y >> ANG_W);
    idx_x = ROM_AW'(scl_x >> ANG_W);
  end
endmodule

// File: rtl/svpwm4_sine_rom.sv
module svpwm4_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic [AW-1:0] addr_x,
  input  logic [AW-1:0] addr_y,
  output logic [DW-1:0] q_x,
  output logic [DW-1:0] q_y
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [DW-1:0] sine_entry(int i);
    real ph;
    ph = 3.14159265358979 * real'(i) / (2.0 * real'(DEPTH));
    return DW'($rtoi(real'((1 << DW) - 1) * $sin(ph)));
  endfunction

  logic [DW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = sine_entry(g);
  end

  assign q_x = tbl[addr_x];
  assign q_y = tbl[addr_y];
endmodule

// File: rtl/svpwm4_base_map.sv
module svpwm4_base_map
  import svpwm4_pkg::*;
#(
  parameter int T_W = 16
) (
  input  logic [2:0]     sec,
  input  logic [T_W-1:0] t_first,
  input  logic [T_W-1:0] t_second,
  input  logic [T_W-1:0] t_zero,
  output logic [T_W-1:0] t1,
  output logic [T_W-1:0] t2,
  output logic [T_W-1:0] t3,
  output logic [T_W-1:0] t4
);
  typedef logic [3:0][T_W-1:0] quad_t;

  // spread one hexagon corner's time onto the physical vectors (index 0 = V1)
  function automatic quad_t place(hexv_e v, logic [T_W-1:0] t);
    quad_t r;
    logic [T_W-1:0] lo, hi;
    r  = '0;
    lo = t >> 1;
    hi = t - lo;
    case (v)
      HV_M23:  begin r[1] = lo; r[2] = hi; end
      HV_B3:   r[2] = t;
      HV_M34:  begin r[2] = lo; r[3] = hi; end
      HV_M41:  begin r[0] = lo; r[3] = hi; end
      HV_B1:   r[0] = t;
      default: begin r[0] = lo; r[1] = hi; end
    endcase
    return r;
  endfunction

  logic [2:0]     sec_nxt;
  quad_t          qa, qb;
  logic [T_W-1:0] z_lo, z_hi;

  always_comb begin
    sec_nxt = (sec == 3'(SECTORS - 1)) ? 3'd0 : sec + 3'd1;
    qa      = place(hex_at(sec), t_first);
    qb      = place(hex_at(sec_nxt), t_second);
    z_lo    = t_zero >> 1;
    z_hi    = t_zero - z_lo;
    t1      = qa[0] + qb[0] + z_lo;
    t2      = qa[1] + qb[1];
    t3      = qa[2] + qb[2] + z_hi;
    t4      = qa[3] + qb[3];
  end
endmodule

// File: rtl/svpwm4_duty.sv
module svpwm4_duty
  import svpwm4_pkg::*;
#(
  parameter int ANG_W  = 16,
  parameter int M_W    = 12,
  parameter int T_W    = 16,
  parameter int SIN_W  = 12,
  parameter int ROM_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ANG_W-1:0] in_angle,
  input  logic [M_W-1:0]   in_mod,
  input  logic [T_W-1:0]   in_half,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_sector,
  output logic [T_W-1:0]   out_t1,
  output logic [T_W-1:0]   out_t2,
  output logic [T_W-1:0]   out_t3,
  output logic [T_W-1:0]   out_t4
);
  localparam int HM_W  = T_W + M_W;
  localparam int PW    = HM_W + SIN_W + SQRT3_W;
  localparam int SHIFT = M_W + SIN_W + SQRT3_FRAC;
  localparam int TA_W  = PW - SHIFT;
  localparam int SUM_W = TA_W + 1;
  localparam int NUM_W = TA_W + T_W;

  stage_e             stage;
  logic [2:0]         sec_c, sec_q;
  logic [ROM_AW-1:0]  ix_c, iy_c, ix_q, iy_q;
  logic [HM_W-1:0]    hm_q;
  logic [T_W-1:0]     h_q;
  logic [SIN_W-1:0]   sx_c, sy_c, sx_q, sy_q;
  logic [TA_W-1:0]    tx_c, ty_c, tx_q, ty_q;
  logic [T_W-1:0]     fx_c, fy_c, f0_c, fx_q, fy_q, f0_q;
  logic [T_W-1:0]     m1, m2, m3, m4;
  logic [PW-1:0]      px, py;
  logic [SUM_W-1:0]   sum_c;
  logic               over_c;
  logic [NUM_W-1:0]   num_c, den_c, quo_c;

  svpwm4_sector_split #(.ANG_W(ANG_W), .ROM_AW(ROM_AW)) u_split (
    .angle(in_angle), .sec(sec_c), .idx_x(ix_c), .idx_y(iy_c)
  );

  svpwm4_sine_rom #(.AW(ROM_AW), .DW(SIN_W)) u_rom (
    .addr_x(ix_q), .addr_y(iy_q), .q_x(sx_c), .q_y(sy_c)
  );

  svpwm4_base_map #(.T_W(T_W)) u_map (
    .sec(sec_q), .t_first(fx_q), .t_second(fy_q), .t_zero(f0_q),
    .t1(m1), .t2(m2), .t3(m3), .t4(m4)
  );

  // active times from the latched table values
  always_comb begin
    px   = PW'(hm_q) * PW'(sx_q) * PW'(SQRT3_K);
    py   = PW'(hm_q) * PW'(sy_q) * PW'(SQRT3_K);
    tx_c = TA_W'(px >> SHIFT);
    ty_c = TA_W'(py >> SHIFT);
  end

  // fit both active times into the half period
  always_comb begin
    sum_c  = SUM_W'(tx_q) + SUM_W'(ty_q);
    over_c = sum_c > SUM_W'(h_q);
    num_c  = NUM_W'(tx_q) * NUM_W'(h_q);
    den_c  = over_c ? NUM_W'(sum_c) : NUM_W'(1);
    quo_c  = num_c / den_c;
    if (over_c) begin
      fx_c = T_W'(quo_c);
      fy_c = h_q - T_W'(quo_c);
      f0_c = '0;
    end else begin
      fx_c = T_W'(tx_q);
      fy_c = T_W'(ty_q);
      f0_c = h_q - T_W'(sum_c);
    end
  end

  assign in_ready = (stage == ST_IDLE) && !out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= ST_IDLE;
      sec_q      <= '0;
      ix_q       <= '0;
      iy_q       <= '0;
      hm_q       <= '0;
      h_q        <= '0;
      sx_q       <= '0;
      sy_q       <= '0;
      tx_q       <= '0;
      ty_q       <= '0;
      fx_q       <= '0;
      fy_q       <= '0;
      f0_q       <= '0;
      out_valid  <= 1'b0;
      out_sector <= '0;
      out_t1     <= '0;
      out_t2     <= '0;
      out_t3     <= '0;
      out_t4     <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (stage)
        ST_IDLE: if (in_valid && in_ready) begin
          sec_q <= sec_c;
          ix_q  <= ix_c;
          iy_q  <= iy_c;
          hm_q  <= HM_W'(in_half) * HM_W'(in_mod);
          h_q   <= in_half;
          stage <= ST_LOOK;
        end
        ST_LOOK: begin
          sx_q  <= sx_c;
          sy_q  <= sy_c;
          stage <= ST_MUL;
        end
        ST_MUL: begin
          tx_q  <= tx_c;
          ty_q  <= ty_c;
          stage <= ST_FIT;
        end
        ST_FIT: begin
          fx_q  <= fx_c;
          fy_q  <= fy_c;
          f0_q  <= f0_c;
          stage <= ST_MAP;
        end
        default: begin
          out_sector <= sec_q + 3'd1;
          out_t1     <= m1;
          out_t2     <= m2;
          out_t3     <= m3;
          out_t4     <= m4;
          out_valid  <= 1'b1;
          stage      <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/svpwm4_duty_chk.sv
module svpwm4_duty_chk #(
  parameter int ANG_W = 16,
  parameter int T_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [ANG_W-1:0] in_angle,
  input logic [T_W-1:0]   in_half,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       out_sector,
  input logic [T_W-1:0]   out_t1,
  input logic [T_W-1:0]   out_t2,
  input logic [T_W-1:0]   out_t3,
  input logic [T_W-1:0]   out_t4
);
  localparam int SW   = T_W + 2;
  localparam int P6_W = ANG_W + 3;

  logic [T_W-1:0]   half_cap;
  logic [ANG_W-1:0] ang_cap;
  logic [3:0]       lat;
  logic [SW-1:0]    t_sum;
  logic [2:0]       exp_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cap <= '0;
      ang_cap  <= '0;
      lat      <= 4'hf;
    end else if (in_valid && in_ready) begin
      half_cap <= in_half;
      ang_cap  <= in_angle;
      lat      <= '0;
    end else if (lat != 4'hf) begin
      lat <= lat + 4'd1;
    end
  end

  always_comb begin
    t_sum   = SW'(out_t1) + SW'(out_t2) + SW'(out_t3) + SW'(out_t4);
    exp_sec = 3'((P6_W'(ang_cap) * P6_W'(6)) >> ANG_W) + 3'd1;
  end

  AST_SECTOR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sector == exp_sec); // R1
  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sector >= 3'd1 && out_sector <= 3'd6)); // R1
  AST_SUM_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> t_sum == SW'(half_cap)); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat == 4'd4); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sector) && $stable(out_t1)
      && $stable(out_t2) && $stable(out_t3) && $stable(out_t4))); // R9
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9
endmodule

bind svpwm4_duty svpwm4_duty_chk #(.ANG_W(ANG_W), .T_W(T_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_angle(in_angle), .in_half(in_half), .out_valid(out_valid),
  .out_ready(out_ready), .out_sector(out_sector), .out_t1(out_t1),
  .out_t2(out_t2), .out_t3(out_t3), .out_t4(out_t4)
);

// File: tb/svpwm4_duty_test.sv
module svpwm4_duty_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_angle, in_half;
  logic [11:0] in_mod;
  logic [2:0]  out_sector;
  logic [15:0] out_t1, out_t2, out_t3, out_t4;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  svpwm4_duty uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .in_mod(in_mod), .in_half(in_half),
    .out_valid(out_valid), .out_ready(out_ready), .out_sector(out_sector),
    .out_t1(out_t1), .out_t2(out_t2), .out_t3(out_t3), .out_t4(out_t4)
  );

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint rom_val(longint i);
    real ph;
    ph = 3.14159265358979 * real'(i) / 512.0;
    return longint'($rtoi(4095.0 * $sin(ph)));
  endfunction

  // R6/R7: share of corner k with time t on base b (0 = V1)
  function automatic longint share(longint k, longint t, int b);
    longint lo, hi;
    lo = t / 2;
    hi = t - lo;
    case (k)
      0: return (b == 1) ? lo : (b == 2) ? hi : 0;   // V23M
      1: return (b == 2) ? t : 0;                    // V3
      2: return (b == 2) ? lo : (b == 3) ? hi : 0;   // V34M
      3: return (b == 0) ? lo : (b == 3) ? hi : 0;   // V41M
      4: return (b == 0) ? t : 0;                    // V1
      default: return (b == 0) ? lo : (b == 1) ? hi : 0; // V12M
    endcase
  endfunction

  task automatic expect_vals(input longint a, input longint m, input longint h,
                             output longint es, output longint e[4], output bit ov);
    longint p6, s, r, ix, iy, tx, ty, fx, fy, f0;
    p6 = a * 6;
    s  = p6 >> 16;
    r  = p6 % 65536;
    ix = ((65536 - r) * 171) >> 16;
    iy = (r * 171) >> 16;
    tx = (h * m * rom_val(ix) * 7094) >> 36;
    ty = (h * m * rom_val(iy) * 7094) >> 36;
    ov = (tx + ty) > h;
    if (ov) begin
      fx = (tx * h) / (tx + ty);
      fy = h - fx;
      f0 = 0;
    end else begin
      fx = tx;
      fy = ty;
      f0 = h - tx - ty;
    end
    for (int b = 0; b < 4; b++)
      e[b] = share(s, fx, b) + share((s + 1) % 6, fy, b);
    e[0] += f0 / 2;
    e[2] += f0 - f0 / 2;
    es = s + 1;
  endtask

  task automatic check_result(longint es, longint e[4], bit ov, longint h);
    string tg;
    tg = ov ? "R5 R2/R3/R6/R7" : "R4 R2/R3/R6/R7";
    check("R9 result valid", out_valid, 1);
    check("R1 sector", out_sector, es);
    check({tg, " t_v1"}, out_t1, e[0]);
    check({tg, " t_v2"}, out_t2, e[1]);
    check({tg, " t_v3"}, out_t3, e[2]);
    check({tg, " t_v4"}, out_t4, e[3]);
    check("R8 sum", longint'(out_t1) + out_t2 + out_t3 + out_t4, h);
  endtask

  task automatic run_one(longint a, longint m, longint h);
    longint es;
    longint e[4];
    bit ov;
    expect_vals(a, m, h, es, e, ov);
    @(negedge clk);
    check("R9 idle ready", in_ready, 1);
    in_valid = 1'b1;
    in_angle = 16'(a);
    in_mod   = 12'(m);
    in_half  = 16'(h);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 not early", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check_result(es, e, ov, h);
  endtask

  longint angs[10] = '{10922, 10923, 21845, 21846, 32768, 43690, 43691, 54613, 54614, 65535};
  longint mods[4]  = '{0, 2000, 2867, 4095};
  longint halfs[4] = '{1, 97, 1000, 65535};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint es1, es2;
    longint e1[4];
    longint e2[4];
    bit ov1, ov2;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_angle = '0; in_mod = '0; in_half = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 out_valid", out_valid, 0);
    check("R10 in_ready", in_ready, 1);
    check("R10 sector", out_sector, 0);
    check("R10 t_v1", out_t1, 0);
    check("R10 t_v3", out_t3, 0);

    for (int mi = 0; mi < 4; mi++)
      for (int hi = 0; hi < 4; hi++) begin
        for (longint a = 0; a < 65536; a += 1021) run_one(a, mods[mi], halfs[hi]);
        for (int k = 0; k < 10; k++) run_one(angs[k], mods[mi], halfs[hi]);
      end

    // R9 back-pressure: second request offered while a result is stalled
    expect_vals(5000, 2867, 1000, es1, e1, ov1);
    expect_vals(40000, 2000, 777, es2, e2, ov2);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_angle = 16'd5000; in_mod = 12'd2867; in_half = 16'd1000;
    @(posedge clk);
    @(negedge clk);
    in_angle = 16'd40000; in_mod = 12'd2000; in_half = 16'd777;
    repeat (4) @(posedge clk);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R9 stall ready low", in_ready, 0);
      check_result(es1, e1, ov1, 1000);
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 released", out_valid, 0);
    check("R9 ready after release", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 queued not early", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check_result(es2, e2, ov2, 777);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule